// File: doc/BRIEF.md
# 3×3 Zero-Padded Window Streamer

This block turns a raster-order stream of 32×32 RGB pixels into a stream of 3×3 neighbourhoods. These feed a stride-1 convolution stage. Each input pixel is 24 bits wide, with one 8-bit field per colour. Pixels are transferred with a valid/ready handshake. A start-of-frame flag marks the first pixel of a frame, and an end-of-line flag marks the last pixel of each row. Every window is centred on one image pixel. Neighbours that fall outside the image read as zero, so each frame yields exactly 32×32 windows.

Internally the block walks a padded grid that is 34 slots wide. Each row has 32 real slots, one per input pixel, followed by two padding slots that the block generates itself. One extra all-padding row at the bottom flushes the last image row. Two 34-stage delay lines hold the two previous padded rows. A 3×3 register array holds the three most recent columns. Padding slots push zeros and need no input beat. Edge positions are masked to zero at the output, so stale data from an earlier frame can never leak into a window. If the output is stalled, the whole pipeline freezes.

Top module: `conv3_window_streamer`

## Requirements
- R1: Each accepted output window centred on image pixel (y, x) carries, in `out_taps[(3*r+c)*24 +: 24]`, the pixel at row y+r-1 and column x+c-1, for r, c in 0..2. Row index 0 is the top of the image and column index 0 is the left.
- R2: Taps whose position lies outside the 32×32 image are zero. Every complete frame produces exactly 1024 windows, in raster order of their centres, with no window missing or repeated.
- R3: `out_first` is high only on the window centred at (0, 0), and `out_last` is high only on the window centred at (31, 31). At `out_last`, exactly 1023 windows have been accepted since the matching `out_first`.
- R4: While the output is never stalled, `in_ready` is low for exactly two cycles after the last pixel of each row is accepted (the padding slots) and for 34 further cycles after the final row (the flush row). This gives 98 low cycles per frame. At all other times `in_ready` is high.
- R5: While `out_valid` is high and `out_ready` is low, the window, its flags and `out_valid` hold unchanged, `in_ready` is low, and no window is lost.
- R6: An accepted beat with `in_sof` high is taken as pixel (0, 0) of a new frame, whatever the current position. Windows already completed from an abandoned partial frame are still delivered. The cycle after the start beat carries no window.
- R7: An accepted beat with `in_eol` high at any column other than 31 sets `err_framing`. The flag stays high until reset, and the beat's pixel is still used.
- R8: After reset, `out_valid` and `err_framing` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts an input pixel this cycle |
| in_pixel | input | 24 | RGB pixel, 8 bits per colour |
| in_sof | input | 1 | First pixel of a frame |
| in_eol | input | 1 | Last pixel of a row |
| out_valid | output | 1 | A window is presented |
| out_ready | input | 1 | Consumer takes the window |
| out_taps | output | 216 | Nine 24-bit taps, tap index 3*row+column |
| out_first | output | 1 | Window centred at (0, 0) |
| out_last | output | 1 | Window centred at (31, 31) |
| err_framing | output | 1 | Sticky misplaced end-of-line flag |

## Verification
Two functions can fall in the same cycle: a consumer stall and an internally generated padding slot at a row end or in the flush row. When they coincide, the padding slot must wait, or the delay lines would slip out of column alignment. The bench provokes this by dropping `out_ready` at random while pixels arrive with random gaps. A scoreboard then judges every accepted window against the values computed from the requirements, and a per-cycle check confirms that a stalled window holds. A frame restart that arrives right after the padding slots of an abandoned partial frame is judged the same way.

// File: rtl/win3_pkg.sv
package win3_pkg;

    localparam int IMG_W_DEF = 32;
    localparam int IMG_H_DEF = 32;
    localparam int CH_W      = 8;
    localparam int N_CH      = 3;
    localparam int PIX_W     = CH_W * N_CH;
    localparam int KSZ       = 3;
    localparam int N_TAPS    = KSZ * KSZ;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        logic top;
        logic bottom;
        logic left;
        logic right;
    } edge_t;

    typedef struct packed {
        logic  emit;
        logic  first;
        logic  last;
        edge_t edges;
    } slot_tag_t;

    function automatic pix_t keep_if(input pix_t p, input logic keep);
        return keep ? p : '0;
    endfunction

endpackage

// File: rtl/win3_slot_ctrl.sv
module win3_slot_ctrl
    import win3_pkg::*;
#(
    parameter int IMG_W = IMG_W_DEF,
    parameter int IMG_H = IMG_H_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  pix_t      in_pixel,
    input  logic      in_sof,
    input  logic      in_eol,
    input  logic      stall,
    output logic      in_ready,
    output logic      fire,
    output pix_t      slot_pix,
    output slot_tag_t tag,
    output logic      err_framing
);

    localparam int ROW_SLOTS = IMG_W + 2;
    localparam int STEP_ROWS = IMG_H + 1;
    localparam int PC_W      = $clog2(ROW_SLOTS);
    localparam int SR_W      = $clog2(STEP_ROWS + 1);

    localparam logic [PC_W-1:0] PC_ONE       = PC_W'(1);
    localparam logic [PC_W-1:0] PC_LAST_PIX  = PC_W'(IMG_W - 1);
    localparam logic [PC_W-1:0] PC_FIRST_PAD = PC_W'(IMG_W);
    localparam logic [PC_W-1:0] PC_END       = PC_W'(ROW_SLOTS - 1);
    localparam logic [SR_W-1:0] SR_ONE       = SR_W'(1);
    localparam logic [SR_W-1:0] SR_FLUSH     = SR_W'(IMG_H);

    logic [PC_W-1:0] pc_q;
    logic [SR_W-1:0] sr_q;
    logic [PC_W-1:0] eff_pc;
    logic [SR_W-1:0] eff_sr;
    logic            pad_slot;
    logic            take;
    logic            restart;
    logic            err_q;

    // A slot is padding in the two columns past the image or in the flush row.
    assign pad_slot = (pc_q >= PC_FIRST_PAD) || (sr_q == SR_FLUSH);
    assign in_ready = !stall && !pad_slot;
    assign take     = in_valid && in_ready;
    assign fire     = take || (pad_slot && !stall);
    assign restart  = take && in_sof;
    assign slot_pix = take ? in_pixel : '0;

    // A start beat is always treated as position (0,0).
    always_comb begin
        eff_pc = restart ? '0 : pc_q;
        eff_sr = restart ? '0 : sr_q;
    end

    always_comb begin
        tag.edges.top    = (eff_sr == SR_ONE);
        tag.edges.bottom = (eff_sr == SR_FLUSH);
        tag.edges.left   = (eff_pc == PC_ONE);
        tag.edges.right  = (eff_pc == PC_FIRST_PAD);
        tag.emit         = (eff_sr != '0) && (eff_pc != '0) && (eff_pc <= PC_FIRST_PAD);
        tag.first        = tag.emit && tag.edges.top && tag.edges.left;
        tag.last         = tag.emit && tag.edges.bottom && tag.edges.right;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
            sr_q <= '0;
        end else if (fire) begin
            if (restart) begin
                pc_q <= PC_ONE;
                sr_q <= '0;
            end else if (pc_q == PC_END) begin
                pc_q <= '0;
                sr_q <= (sr_q == SR_FLUSH) ? '0 : sr_q + SR_ONE;
            end else begin
                pc_q <= pc_q + PC_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (take && in_eol && (eff_pc != PC_LAST_PIX)) begin
            err_q <= 1'b1;
        end
    end

    assign err_framing = err_q;

    // R4: the slot after the last pixel of a row never takes input
    assert_row_gap_R4: assert property (@(posedge clk) disable iff (rst)
        (take && !restart && (pc_q == PC_LAST_PIX)) |=> !in_ready);

    // R7: the framing flag never clears outside reset
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);

endmodule

// File: rtl/win3_row_delay.sv
module win3_row_delay
    import win3_pkg::*;
#(
    parameter int DEPTH = IMG_W_DEF + 2
) (
    input  logic clk,
    input  logic en,
    input  pix_t din,
    output pix_t dout
);

    pix_t stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            stage_q[0] <= din;
            for (int i = 1; i < DEPTH; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/win3_tap_array.sv
module win3_tap_array
    import win3_pkg::*;
#(
    parameter int IMG_W = IMG_W_DEF,
    parameter int IMG_H = IMG_H_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fire,
    input  pix_t [KSZ-1:0]          row_in,
    input  slot_tag_t               tag_in,
    input  logic                    out_ready,
    output logic                    out_valid,
    output logic [N_TAPS*PIX_W-1:0] out_taps,
    output logic                    out_first,
    output logic                    out_last
);

    localparam int WIN_TOTAL = IMG_W * IMG_H;
    localparam int CNT_W     = $clog2(WIN_TOTAL + 1);

    pix_t            win_q [KSZ][KSZ];
    slot_tag_t       tag_q;
    logic            valid_q;
    logic [CNT_W-1:0] seen_q;

    // Column KSZ-1 is the newest slot; older columns shift left.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < KSZ; r++) begin
                for (int c = 0; c < KSZ; c++) begin
                    win_q[r][c] <= '0;
                end
            end
            tag_q <= '0;
        end else if (fire) begin
            for (int r = 0; r < KSZ; r++) begin
                for (int c = 0; c < KSZ - 1; c++) begin
                    win_q[r][c] <= win_q[r][c+1];
                end
                win_q[r][KSZ-1] <= row_in[r];
            end
            tag_q <= tag_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
        end else if (fire) begin
            valid_q <= tag_in.emit;
        end else if (out_ready) begin
            valid_q <= 1'b0;
        end
    end

    for (genvar r = 0; r < KSZ; r++) begin : g_row
        for (genvar c = 0; c < KSZ; c++) begin : g_col
            logic keep;
            assign keep = !((r == 0)       && tag_q.edges.top)
                       && !((r == KSZ - 1) && tag_q.edges.bottom)
                       && !((c == 0)       && tag_q.edges.left)
                       && !((c == KSZ - 1) && tag_q.edges.right);
            assign out_taps[(r*KSZ+c)*PIX_W +: PIX_W] = keep_if(win_q[r][c], keep);
        end
    end

    assign out_valid = valid_q;
    assign out_first = valid_q && tag_q.first;
    assign out_last  = valid_q && tag_q.last;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (out_valid && out_ready) begin
            seen_q <= out_first ? CNT_W'(1) : seen_q + CNT_W'(1);
        end
    end

    // R5: a stalled window holds
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_taps)
                                       && $stable(out_first) && $stable(out_last)));

    // R3: the last window closes a full frame
    assert_last_after_full_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_last) |-> (seen_q == CNT_W'(WIN_TOTAL - 1)));

    // R2: the top row of the first window is border
    assert_corner_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_first) |-> (out_taps[KSZ*PIX_W-1:0] == '0));

endmodule

// File: rtl/conv3_window_streamer.sv
module conv3_window_streamer
    import win3_pkg::*;
#(
    parameter int IMG_W = IMG_W_DEF,
    parameter int IMG_H = IMG_H_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [PIX_W-1:0]        in_pixel,
    input  logic                    in_sof,
    input  logic                    in_eol,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [N_TAPS*PIX_W-1:0] out_taps,
    output logic                    out_first,
    output logic                    out_last,
    output logic                    err_framing
);

    localparam int LINE_DEPTH = IMG_W + 2;
    localparam int N_LINES    = KSZ - 1;

    logic               stall;
    logic               fire;
    pix_t               slot_pix;
    slot_tag_t          tag;
    pix_t [N_LINES-1:0] line_in;
    pix_t [N_LINES-1:0] line_out;
    pix_t [KSZ-1:0]     row_in;

    assign stall = out_valid && !out_ready;

    win3_slot_ctrl #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_pixel   (in_pixel),
        .in_sof     (in_sof),
        .in_eol     (in_eol),
        .stall      (stall),
        .in_ready   (in_ready),
        .fire       (fire),
        .slot_pix   (slot_pix),
        .tag        (tag),
        .err_framing(err_framing)
    );

    // Chain of padded-row delays; line g feeds window row KSZ-2-g.
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        if (g == 0) begin : g_head
            assign line_in[g] = slot_pix;
        end else begin : g_tail
            assign line_in[g] = line_out[g-1];
        end
        win3_row_delay #(.DEPTH(LINE_DEPTH)) u_delay (
            .clk (clk),
            .en  (fire),
            .din (line_in[g]),
            .dout(line_out[g])
        );
        assign row_in[KSZ-2-g] = line_out[g];
    end
    assign row_in[KSZ-1] = slot_pix;

    win3_tap_array #(.IMG_W(IMG_W), .IMG_H(IMG_H)) u_taps (
        .clk      (clk),
        .rst      (rst),
        .fire     (fire),
        .row_in   (row_in),
        .tag_in   (tag),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_taps (out_taps),
        .out_first(out_first),
        .out_last (out_last)
    );

    // R6: a frame start yields no window in the following cycle
    assert_sof_no_window_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_sof) |=> !out_valid);

endmodule

// File: tb/conv3_window_streamer_tb.sv
module conv3_window_streamer_tb;
    import win3_pkg::*;

    localparam int W = 32;
    localparam int H = 32;

    typedef struct packed {
        logic [N_TAPS*PIX_W-1:0] taps;
        logic                    first;
        logic                    last;
    } exp_t;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic                    rst = 1'b1;
    logic                    in_valid = 1'b0;
    logic                    in_ready;
    logic [PIX_W-1:0]        in_pixel = '0;
    logic                    in_sof = 1'b0;
    logic                    in_eol = 1'b0;
    logic                    out_valid;
    logic                    out_ready = 1'b1;
    logic [N_TAPS*PIX_W-1:0] out_taps;
    logic                    out_first;
    logic                    out_last;
    logic                    err_framing;

    conv3_window_streamer #(.IMG_W(W), .IMG_H(H)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_pixel(in_pixel), .in_sof(in_sof), .in_eol(in_eol),
        .out_valid(out_valid), .out_ready(out_ready), .out_taps(out_taps),
        .out_first(out_first), .out_last(out_last), .err_framing(err_framing)
    );

    int   n_cmp = 0;
    int   n_bad = 0;
    exp_t exp_q[$];
    bit   bp_on = 1'b0;
    bit   rl_en = 1'b0;
    int   rl_cnt = 0;

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    function automatic pix_t pix_of(int f, int y, int x);
        return {8'(f * 29 + 3), 8'(y + 1), 8'(x + 1)};
    endfunction

    // R1/R2: neighbourhood with zero outside the image
    function automatic exp_t make_exp(int f, int y, int x);
        exp_t e;
        int yy;
        int xx;
        e.taps = '0;
        for (int r = 0; r < KSZ; r++) begin
            for (int c = 0; c < KSZ; c++) begin
                yy = y + r - 1;
                xx = x + c - 1;
                if (yy >= 0 && yy < H && xx >= 0 && xx < W)
                    e.taps[(r*KSZ+c)*PIX_W +: PIX_W] = pix_of(f, yy, xx);
            end
        end
        e.first = (y == 0 && x == 0);
        e.last  = (y == H - 1 && x == W - 1);
        return e;
    endfunction

    // Monitor: drives back-pressure, checks holds and pops the scoreboard.
    initial begin
        exp_t                    e;
        bit                      prev_stall = 1'b0;
        logic [N_TAPS*PIX_W-1:0] prev_taps = '0;
        forever begin
            @(negedge clk);
            out_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
            #2;
            if (!rst) begin
                if (rl_en && !in_ready) rl_cnt++;
                if (prev_stall)
                    chk("R5 stalled window held", {out_valid, out_taps}, {1'b1, prev_taps});
                if (out_valid && !out_ready)
                    chk("R5 no input taken while stalled", in_ready, 0);
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        chk("R2 unexpected extra window", 1, 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk("R1 window taps", out_taps, e.taps);
                        chk("R3 first flag", out_first, e.first);
                        chk("R3 last flag", out_last, e.last);
                    end
                end
                prev_stall = out_valid && !out_ready;
                prev_taps  = out_taps;
            end
        end
    end

    task automatic send_frame(input int f, input int rows, input bit gaps,
                              input int bad_y, input int bad_x);
        int win_rows;
        win_rows = (rows == H) ? H : rows - 1;
        for (int y = 0; y < win_rows; y++)
            for (int x = 0; x < W; x++)
                exp_q.push_back(make_exp(f, y, x));
        for (int y = 0; y < rows; y++) begin
            for (int x = 0; x < W; x++) begin
                if (gaps && ($urandom % 4 == 0)) begin
                    @(negedge clk);
                    in_valid = 1'b0;
                end
                @(negedge clk);
                in_valid = 1'b1;
                in_pixel = pix_of(f, y, x);
                in_sof   = (y == 0 && x == 0);
                in_eol   = (x == W - 1) || (y == bad_y && x == bad_x);
                #1;
                while (!in_ready) begin
                    @(negedge clk);
                    #1;
                end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_eol   = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 6000 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (6) @(negedge clk);
        chk("R2 all expected windows delivered", exp_q.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R8 reset out_valid", out_valid, 0);
        chk("R8 reset in_ready", in_ready, 1);
        chk("R8 reset err_framing", err_framing, 0);

        // Full-rate frame, no stall: padding slots counted (R4)
        rl_cnt = 0;
        rl_en  = 1'b1;
        send_frame(0, H, 1'b0, -1, -1);
        drain();
        rl_en = 1'b0;
        chk("R4 ready-low cycles per frame", rl_cnt, 2 * H + W + 2);
        chk("R7 clean frame leaves flag low", err_framing, 0);

        // Gaps and random back-pressure (R5, R1, R2)
        bp_on = 1'b1;
        send_frame(1, H, 1'b1, -1, -1);
        drain();

        // Partial frame abandoned by a new start (R6)
        send_frame(2, 10, 1'b1, -1, -1);
        send_frame(3, H, 1'b1, -1, -1);
        drain();
        chk("R6 restart delivered every window", exp_q.size(), 0);
        chk("R7 flag still low", err_framing, 0);

        // Misplaced end-of-line (R7)
        bp_on = 1'b0;
        send_frame(4, H, 1'b0, 5, 10);
        drain();
        chk("R7 misplaced eol sets flag", err_framing, 1);

        send_frame(5, H, 1'b1, -1, -1);
        drain();
        chk("R7 flag sticky after clean frame", err_framing, 1);

        summary();
        $finish;
    end

endmodule